// File: doc/BRIEF.md
# Parallel I/O Port with Edge-Capture Interrupt

This block is a bus-attached parallel I/O port of up to 32 pins. A host reaches four word registers through a plain address, write-enable, write-data and read-data interface: the pin levels, a per-pin drive enable, a per-pin interrupt enable and a per-pin event latch. A pin whose enable bit is set is driven from the stored pin level. A pin whose enable bit is clear is sampled through a two-stage synchronizer and reads back through the same level register.

How pins raise an interrupt is fixed when the block is built: on rising transitions, on falling transitions, on either transition, or while the pin is high. In the three transition modes each detected transition sets a sticky bit in the event latch. The host clears that bit by writing a one to it. The single interrupt line is high whenever an enabled latched bit is set. In the high-level mode nothing is latched, and the line follows the enabled synchronized pin levels directly.

Top module: `pio_irq_unit`

## Requirements
- R1: After reset every register reads zero, `irqOut` is low and `pinOut` and `pinOe` are zero.
- R2: Address bits [3:2] select the register: 0 level, 1 drive enable, 2 interrupt enable, 3 event latch. Address bits [1:0] are ignored. A write to the drive enable register appears on `pinOe` on the cycle after the write. A bit value of 1 makes the pin an output.
- R3: A write to the level register stores the value. `pinOut` carries that stored value on pins whose drive enable bit is 1, and 0 on all other pins.
- R4: Reading the level register returns the stored value for output pins and the synchronized pin value for input pins. A pin change is visible after the second rising clock edge that follows it, and is not visible after the first.
- R5: In rising mode a 0-to-1 pin transition sets that pin's event bit. The bit is still clear after the second clock edge that follows the change, and set after the third.
- R6: In falling mode a 1-to-0 transition sets the event bit. Rising transitions leave it unchanged.
- R7: In both-edge mode either transition sets the event bit.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R9: When a new transition on a pin is detected in the same cycle as a clearing write to that pin's bit, the bit stays set.
- R10: In the transition modes `irqOut` is high exactly when some bit is set in both the event latch and the interrupt enable register (enable bit 1 means enabled).
- R11: In high-level mode `irqOut` is high exactly when some synchronized pin that is high also has its enable bit set. The event latch always reads zero in this mode.
- R12: Register bits at or above `PIN_COUNT` read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Byte address; bits [3:2] select the register |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed register (combinational) |
| pinIn | input | PIN_COUNT | Pin levels from the pads |
| pinOut | output | PIN_COUNT | Levels driven to the pads |
| pinOe | output | PIN_COUNT | Per-pin drive enable for the pads |
| irqOut | output | 1 | Interrupt request to the host |

## Verification
A stale or mis-set event bit shows up in two places. It appears on the event-latch readback as soon as the bench reads it, and on `irqOut` in that same cycle whenever the bit is enabled. A broken synchronizer or edge comparator shifts the cycle in which a change appears: the readback becomes visible one edge early or late, or the event bit lands one cycle off. The bench therefore samples at exact edge counts after each pin change. A clear that wins over a new event loses that event for good, so the collision case is lined up to the exact cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int MAX_PINS = 32;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_DRIVE = 2'd1,
    SEL_ENAB  = 2'd2,
    SEL_EVENT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrLevel;
    logic    wrDrive;
    logic    wrEnab;
    logic    clrEvent;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobe_t           ctl
);

  regSel_e sel;
  logic    unusedAddrBits;

  assign sel            = regSel_e'(busAddr[3:2]);
  assign unusedAddrBits = ^busAddr[1:0];

  always_comb begin
    ctl          = '0;
    ctl.rdSel    = sel;
    ctl.wrLevel  = busWrEn && (sel == SEL_LEVEL);
    ctl.wrDrive  = busWrEn && (sel == SEL_DRIVE);
    ctl.wrEnab   = busWrEn && (sel == SEL_ENAB);
    ctl.clrEvent = busWrEn && (sel == SEL_EVENT);
  end

endmodule

// File: rtl/pio_sync_edge.sv
module pio_sync_edge
  import pio_pkg::*;
#(
  parameter int    PIN_COUNT = 32,
  parameter trig_e TRIGGER   = TRIG_RISE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] syncVal,
  output logic [PIN_COUNT-1:0] edgeEv
);

  logic [PIN_COUNT-1:0] stage1;
  logic [PIN_COUNT-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= pinIn;
      stage2 <= stage1;
    end
  end

  assign syncVal = stage2;

  generate
    if (TRIGGER == TRIG_LEVEL) begin : g_level
      assign edgeEv = '0;
    end else begin : g_edge
      logic [PIN_COUNT-1:0] prevVal;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevVal <= '0;
        else       prevVal <= stage2;
      end

      if (TRIGGER == TRIG_RISE) begin : g_rise
        assign edgeEv = stage2 & ~prevVal;
      end else if (TRIGGER == TRIG_FALL) begin : g_fall
        assign edgeEv = ~stage2 & prevVal;
      end else begin : g_both
        assign edgeEv = stage2 ^ prevVal;
      end
    end
  endgenerate

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int    PIN_COUNT = 32,
  parameter trig_e TRIGGER   = TRIG_RISE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              ctl,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [PIN_COUNT-1:0] syncVal,
  input  logic [PIN_COUNT-1:0] edgeEv,
  output logic [DATA_W-1:0]    rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] maskQ,
  output logic [PIN_COUNT-1:0] capQ,
  output logic                 irqOut
);

  logic [PIN_COUNT-1:0] levelQ;
  logic [PIN_COUNT-1:0] driveQ;
  logic [PIN_COUNT-1:0] capNext;
  logic [PIN_COUNT-1:0] wrBits;
  logic [PIN_COUNT-1:0] rdVal;
  logic [PIN_COUNT-1:0] levelView;

  assign wrBits = wrData[PIN_COUNT-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      driveQ <= '0;
      maskQ  <= '0;
      capQ   <= '0;
    end else begin
      if (ctl.wrLevel) levelQ <= wrBits;
      if (ctl.wrDrive) driveQ <= wrBits;
      if (ctl.wrEnab)  maskQ  <= wrBits;
      capQ <= capNext;
    end
  end

  generate
    if (TRIGGER == TRIG_LEVEL) begin : g_lvl
      assign capNext = '0;
      assign irqOut  = |(syncVal & maskQ);
    end else begin : g_edg
      logic [PIN_COUNT-1:0] clrBits;
      assign clrBits = ctl.clrEvent ? wrBits : '0;
      assign capNext = (capQ & ~clrBits) | edgeEv;
      assign irqOut  = |(capQ & maskQ);
    end
  endgenerate

  assign levelView = (levelQ & driveQ) | (syncVal & ~driveQ);
  assign pinOut    = levelQ & driveQ;
  assign pinOe     = driveQ;

  always_comb begin
    unique case (ctl.rdSel)
      SEL_LEVEL: rdVal = levelView;
      SEL_DRIVE: rdVal = driveQ;
      SEL_ENAB:  rdVal = maskQ;
      default:   rdVal = capQ;
    endcase
  end

  assign rdData = DATA_W'(rdVal);

endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit
  import pio_pkg::*;
#(
  parameter int    PIN_COUNT = 32,
  parameter trig_e TRIGGER   = TRIG_RISE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  initial begin
    if (PIN_COUNT < 1 || PIN_COUNT > MAX_PINS)
      $error("PIN_COUNT out of range");
  end

  strobe_t              ctl;
  logic [PIN_COUNT-1:0] syncVal;
  logic [PIN_COUNT-1:0] edgeEv;
  logic [PIN_COUNT-1:0] maskQ;
  logic [PIN_COUNT-1:0] capQ;

  pio_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .ctl     (ctl)
  );

  pio_sync_edge #(
    .PIN_COUNT (PIN_COUNT),
    .TRIGGER   (TRIGGER)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .syncVal (syncVal),
    .edgeEv  (edgeEv)
  );

  pio_datapath #(
    .PIN_COUNT (PIN_COUNT),
    .TRIGGER   (TRIGGER)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (busWrData),
    .syncVal (syncVal),
    .edgeEv  (edgeEv),
    .rdData  (busRdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .maskQ   (maskQ),
    .capQ    (capQ),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/pio_irq_checker.sv
module pio_irq_checker
  import pio_pkg::*;
#(
  parameter int PIN_COUNT = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [DATA_W-1:0]    busWrData,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic                 irqOut,
  input logic [PIN_COUNT-1:0] maskQ,
  input logic [PIN_COUNT-1:0] capQ
);

  // R2: a drive-enable write reaches pinOe one cycle later
  p_drive_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[3:2] == 2'd1) |=> (pinOe == $past(busWrData[PIN_COUNT-1:0])));

  // R3: a level write reaches the pads that are enabled for drive
  p_level_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[3:2] == 2'd0) |=>
      (pinOut == ($past(busWrData[PIN_COUNT-1:0]) & pinOe)));

  // R10 and R11: no interrupt without at least one enabled pin
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ != '0));

  // R8: event bits are sticky unless a clearing write is made
  p_event_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr[3:2] == 2'd3) |=> ((capQ & $past(capQ)) == $past(capQ)));

  // R12: the interrupt enable register takes the written value
  p_enable_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[3:2] == 2'd2) |=> (maskQ == $past(busWrData[PIN_COUNT-1:0])));

endmodule

bind pio_irq_unit pio_irq_checker #(
  .PIN_COUNT (PIN_COUNT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .irqOut    (irqOut),
  .maskQ     (maskQ),
  .capQ      (capQ)
);

// File: tb/pio_irq_unit_bench.sv
`timescale 1ns/1ps
module pio_irq_unit_bench;
  import pio_pkg::*;

  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [P-1:0] pins = '0;

  logic [31:0] rdR, rdF, rdB, rdL;
  logic        irqR, irqF, irqB, irqL;
  logic [P-1:0] pinOut, pinOe;
  logic [P-1:0] outF, oeF, outB, oeB, outL, oeL;

  int checks = 0;
  int errors = 0;

  logic [P-1:0] expR = '0, expF = '0, expB = '0, maskM = '0;

  always #2 clk = ~clk;

  pio_irq_unit #(.PIN_COUNT(P), .TRIGGER(TRIG_RISE)) u_pio_irq_unit (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rdR), .pinIn(pins), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqR));
  pio_irq_unit #(.PIN_COUNT(P), .TRIGGER(TRIG_FALL)) u_fall (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rdF), .pinIn(pins), .pinOut(outF), .pinOe(oeF), .irqOut(irqF));
  pio_irq_unit #(.PIN_COUNT(P), .TRIGGER(TRIG_BOTH)) u_both (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rdB), .pinIn(pins), .pinOut(outB), .pinOe(oeB), .irqOut(irqB));
  pio_irq_unit #(.PIN_COUNT(P), .TRIGGER(TRIG_LEVEL)) u_level (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rdL), .pinIn(pins), .pinOut(outL), .pinOe(oeL), .irqOut(irqL));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    busAddr = a;
    #1;
  endtask

  task automatic setPins(input logic [P-1:0] v);
    expR |= v & ~pins;
    expF |= pins & ~v;
    expB |= pins ^ v;
    pins = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clearEv(input logic [P-1:0] v);
    wr(4'hC, {24'hFFFFFF, v});
    expR &= ~v; expF &= ~v; expB &= ~v;
  endtask

  task automatic checkAll(input string tag);
    rd(4'hC);
    chk({"R5 ", tag}, rdR, 32'(expR));
    chk({"R6 ", tag}, rdF, 32'(expF));
    chk({"R7 ", tag}, rdB, 32'(expB));
    chk({"R11 ", tag}, rdL, 32'h0);
    chk({"R10 ", tag}, 32'(irqR), 32'(|(expR & maskM)));
    chk({"R10 ", tag}, 32'(irqF), 32'(|(expF & maskM)));
    chk({"R10 ", tag}, 32'(irqB), 32'(|(expB & maskM)));
    chk({"R11 ", tag}, 32'(irqL), 32'(|(pins & maskM)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4));
      chk("R1 rise", rdR, 0); chk("R1 fall", rdF, 0);
      chk("R1 both", rdB, 0); chk("R1 level", rdL, 0);
    end
    chk("R1 irq", {28'h0, irqR, irqF, irqB, irqL}, 0);
    chk("R1 pads", {16'h0, pinOut, pinOe}, 0);

    // R12 upper bits ignored, R2 low address bits ignored
    wr(4'hB, 32'hFFFF_FFFF);
    maskM = 8'hFF;
    rd(4'h8);
    chk("R12 mask", rdR, 32'h0000_00FF);
    chk("R12 mask level", rdL, 32'h0000_00FF);
    wr(4'h8, 32'h0000_0000);
    maskM = '0;

    // R2 / R3 drive and level
    wr(4'h5, 32'h1234_560F);
    chk("R2 pinOe", 32'(pinOe), 32'h0F);
    rd(4'h4);
    chk("R12 drive", rdR, 32'h0000_000F);
    wr(4'h0, 32'hFFFF_FFA5);
    chk("R3 pinOut", 32'(pinOut), 32'h05);
    setPins(8'h3C);
    settle();
    rd(4'h0);
    chk("R4 mixed", rdR, 32'h35);

    // R4 latency: pin 7 rises
    setPins(8'hBC);
    @(negedge clk);
    rd(4'h0);
    chk("R4 one edge", rdR, 32'h35);
    @(negedge clk);
    rd(4'h0);
    chk("R4 two edges", rdR, 32'hB5);
    settle();
    checkAll("after mixed");
    clearEv(8'hFF);
    checkAll("cleared");

    // Sweep of pin patterns, masks and clears
    for (int i = 0; i < 64; i++) begin
      setPins(8'((i * 37 + 11) ^ (i >> 1)));
      settle();
      checkAll("sweep");
      if (i % 4 == 0) begin
        maskM = 8'(i * 29 + 3);
        wr(4'h8, 32'(maskM));
        checkAll("mask");
      end
      if (i % 3 == 0) begin
        clearEv(8'(i * 53 + 7));
        checkAll("R8 clear");
      end
    end

    // R8: a zero write keeps the bits
    setPins(8'h00); settle();
    setPins(8'hFF); settle();
    wr(4'hC, 32'h0000_0000);
    checkAll("R8 zero write");

    // R5 latency and R9 collision
    clearEv(8'hFF);
    setPins(8'h00); settle();
    clearEv(8'hFF);
    setPins(8'h01);
    @(negedge clk); @(negedge clk);
    rd(4'hC);
    chk("R5 two edges", rdR, 32'h0);
    @(negedge clk);
    rd(4'hC);
    chk("R5 three edges", rdR, 32'h1);
    settle();
    setPins(8'h00); settle();
    checkAll("before collision");
    setPins(8'h01);
    @(negedge clk); @(negedge clk);
    wr(4'hC, 32'h1);
    expF &= ~8'h01;
    rd(4'hC);
    chk("R9 rise kept", rdR, 32'h1);
    chk("R9 both kept", rdB, 32'h1);
    chk("R8 fall cleared", rdF, 32'h0);
    settle();
    checkAll("final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule